// File: doc/BRIEF.md
# Integer Load/Store Address and Data Formatter

This block sits between an instruction decoder and a 32-bit data memory port. It takes one decoded integer load or store at a time. It forms the effective address from a base register, an index register or a signed 16-bit displacement. It issues one word-wide memory request with byte enables. When the response returns, it shapes the loaded data for the target register and, for update forms, writes the effective address back into the base register. Accesses flagged as alignment-checked (the floating-point class) raise an exception instead of a request when the address is not word aligned.

The memory bus is 32 bits wide and big-endian. Byte lane 3 (bits 31:24) holds the byte whose address has low bits 00, and lane 0 (bits 7:0) holds low bits 11. A halfword uses the upper lane pair when address bit 1 is 0 and the lower pair when it is 1. A word uses all four lanes. Integer accesses that are not naturally aligned keep the lanes of their containing halfword or word. Size codes on `op_size` are 0 for byte, 1 for halfword, and 2 or 3 for word.

Top module: `lsu_addr_fmt`

## Requirements
- R1: In displacement form (`op_indexed`=0), the request address is the base plus the sign-extended `disp`. The base is `ra_val`, except that it is zero when `ra_idx` is 0 and `op_update` is 0.
- R2: In indexed form (`op_indexed`=1), the request address is the base plus `rb_val`. The base is chosen as in R1, so a zero `ra_idx` in a non-update operation gives `rb_val` alone.
- R3: With `op_update`=1, the base is always `ra_val`, even when `ra_idx` is 0. A response without fault produces `base_we`=1, `base_waddr`=`ra_idx` and `base_wdata` equal to the request address, for loads and stores alike.
- R4: A response with `mem_rsp_fault`=1 produces neither a register write (`rf_we`) nor a base write (`base_we`).
- R5: A byte load writes the byte from lane 3 minus the address low two bits, zero-extended to 32 bits. It ignores `op_signed` and `op_brev`.
- R6: A halfword load takes the lane pair selected by address bit 1. It is sign-extended from bit 15 when `op_signed`=1 and zero-extended otherwise.
- R7: With `op_brev`=1, a halfword load swaps its two bytes before any extension, and a word load reverses all four bytes. A word load with `op_brev`=0 writes the response word unchanged.
- R8: A store drives `mem_req_we`=1. A byte store sets the single enable bit 3 minus the address low bits and places `st_data[7:0]` in that lane. A halfword store sets enables 4'b1100 or 4'b0011 by address bit 1 and places `st_data[15:0]` there, byte-swapped when `op_brev`=1. A word store sets 4'b1111 with `st_data`, byte-reversed when `op_brev`=1. Lanes that are not enabled carry zero. Loads drive `mem_req_we`=0 and set the same enables as a store of that size.
- R9: When `op_align`=1 and either low bit of the address is set, `align_exc` is 1 for the cycle after acceptance. No request is issued and no register or base write follows. With both low bits clear, the access proceeds normally.
- R10: An operation is accepted on a cycle with `op_valid` and `op_ready` both high. `mem_req_valid` rises the next cycle and holds its address, enables and data unchanged until `mem_req_ready`. `op_ready` stays low until the response has been taken. The writes of R3 to R7 appear in the cycle after `mem_rsp_valid`, and `rf_we`=1 only for loads.
- R11: After reset, `op_ready` is 1 and `mem_req_valid`, `rf_we`, `base_we` and `align_exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and able to accept |
| op_store | input | 1 | 1 for store, 0 for load |
| op_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| op_signed | input | 1 | Sign-extend halfword load |
| op_brev | input | 1 | Byte-reversed halfword or word |
| op_update | input | 1 | Write address back into base register |
| op_indexed | input | 1 | Index register instead of displacement |
| op_align | input | 1 | Alignment-checked access class |
| ra_idx | input | 5 | Base register index |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| rt_idx | input | 5 | Target register index for loads |
| st_data | input | 32 | Source register value for stores |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte effective address |
| mem_req_we | output | 1 | Write request |
| mem_req_be | output | 4 | Byte enables, bit 3 is the lowest address |
| mem_req_wdata | output | 32 | Store data in lanes |
| mem_rsp_valid | input | 1 | Response present for one cycle |
| mem_rsp_data | input | 32 | Read word |
| mem_rsp_fault | input | 1 | Data storage fault |
| rf_we | output | 1 | Target register write |
| rf_waddr | output | 5 | Target register index |
| rf_wdata | output | 32 | Formatted load value |
| base_we | output | 1 | Base register write |
| base_waddr | output | 5 | Base register index |
| base_wdata | output | 32 | Effective address for update |
| align_exc | output | 1 | Alignment exception pulse |

## Verification
The hardest case to reach is the combination of an update form with base index zero, a data fault, and a stalled request. Here the base selection, write suppression and request holding all interact. Only the full cross product of operation fields against address low bits and fault reaches every such combination. The stimulus sweeps every store flag, size, sign, byte-reverse, update, indexed, zero-index, lane and fault setting. It varies the request stall and the response gap with the sweep index and rotates the response word so that every lane sees both sign values. A separate sweep drives alignment-checked accesses at all four low-bit offsets.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } size_e;

  typedef struct packed {
    logic  store;
    size_e size;
    logic  sext;
    logic  brev;
    logic  update;
  } op_t;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              indexed,
  input  logic              update,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] ea
);
  localparam int EXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] offs;

  always_comb begin
    base = (update || (ra_idx != '0)) ? ra_val : '0;
    offs = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
    ea   = base + offs;
  end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
  import lsu_pkg::*;
(
  input  size_e             size,
  input  logic              brev,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] rep;
  logic [15:0]       half;

  always_comb begin
    half = brev ? swap16(src[15:0]) : src[15:0];
    case (size)
      SZ_BYTE: begin
        be  = 4'b1000 >> lo;
        rep = {4{src[7:0]}};
      end
      SZ_HALF: begin
        be  = lo[1] ? 4'b0011 : 4'b1100;
        rep = {2{half}};
      end
      default: begin
        be  = 4'b1111;
        rep = brev ? swap32(src) : src;
      end
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wdata[8*k +: 8] = be[k] ? rep[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  size_e             size,
  input  logic              sext,
  input  logic              brev,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] shifted;
  logic [15:0]       half_raw;
  logic [15:0]       half;

  always_comb begin
    shifted  = rdata >> {2'd3 - lo, 3'b000};
    half_raw = lo[1] ? rdata[15:0] : rdata[31:16];
    half     = brev ? swap16(half_raw) : half_raw;
    case (size)
      SZ_BYTE: value = {24'h0, shifted[7:0]};
      SZ_HALF: value = {{16{sext & half[15]}}, half};
      default: value = brev ? swap32(rdata) : rdata;
    endcase
  end
endmodule

// File: rtl/lsu_addr_fmt.sv
module lsu_addr_fmt
  import lsu_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic              op_brev,
  input  logic              op_update,
  input  logic              op_indexed,
  input  logic              op_align,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [31:0]       ra_val,
  input  logic [31:0]       rb_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [31:0]       st_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic              mem_req_we,
  output logic [3:0]        mem_req_be,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_fault,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [31:0]       rf_wdata,
  output logic              base_we,
  output logic [IDX_W-1:0]  base_waddr,
  output logic [31:0]       base_wdata,
  output logic              align_exc
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;

  state_e            state;
  op_t               cur_op;
  op_t               held_op;
  logic [IDX_W-1:0]  held_rt;
  logic [IDX_W-1:0]  held_ra;
  logic [DATA_W-1:0] ea;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] ld_value;
  logic              accept;
  logic              misaligned;

  assign cur_op = '{store: op_store, size: size_e'(op_size), sext: op_signed,
                    brev: op_brev, update: op_update};

  lsu_agen #(.DISP_W(DISP_W), .IDX_W(IDX_W)) u_agen (
    .indexed (op_indexed),
    .update  (op_update),
    .ra_idx  (ra_idx),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .disp    (disp),
    .ea      (ea)
  );

  lsu_store_fmt u_sfmt (
    .size  (cur_op.size),
    .brev  (op_brev),
    .lo    (ea[1:0]),
    .src   (st_data),
    .be    (st_be),
    .wdata (st_wdata)
  );

  lsu_load_fmt u_lfmt (
    .size  (held_op.size),
    .sext  (held_op.sext),
    .brev  (held_op.brev),
    .lo    (mem_req_addr[1:0]),
    .rdata (mem_rsp_data),
    .value (ld_value)
  );

  assign op_ready      = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign accept        = op_valid && op_ready;
  assign misaligned    = op_align && (ea[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      held_op       <= '0;
      held_rt       <= '0;
      held_ra       <= '0;
      mem_req_addr  <= '0;
      mem_req_we    <= 1'b0;
      mem_req_be    <= '0;
      mem_req_wdata <= '0;
      rf_we         <= 1'b0;
      rf_waddr      <= '0;
      rf_wdata      <= '0;
      base_we       <= 1'b0;
      base_waddr    <= '0;
      base_wdata    <= '0;
      align_exc     <= 1'b0;
    end else begin
      rf_we     <= 1'b0;
      base_we   <= 1'b0;
      align_exc <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (misaligned) begin
              align_exc <= 1'b1;
            end else begin
              state         <= S_REQ;
              held_op       <= cur_op;
              held_rt       <= rt_idx;
              held_ra       <= ra_idx;
              mem_req_addr  <= ea;
              mem_req_we    <= op_store;
              mem_req_be    <= st_be;
              mem_req_wdata <= op_store ? st_wdata : '0;
            end
          end
        end
        S_REQ: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            state <= S_IDLE;
            if (!mem_rsp_fault) begin
              rf_we      <= !held_op.store;
              rf_waddr   <= held_rt;
              rf_wdata   <= ld_value;
              base_we    <= held_op.update;
              base_waddr <= held_ra;
              base_wdata <= mem_req_addr;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_addr_fmt_chk.sv
module lsu_addr_fmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic       op_ready,
  input logic       mem_req_valid,
  input logic       mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic [3:0] mem_req_be,
  input logic [31:0] mem_req_wdata,
  input logic       mem_rsp_valid,
  input logic       mem_rsp_fault,
  input logic       rf_we,
  input logic       base_we,
  input logic       align_exc
);
  // R9: an alignment exception comes with no request and no writes
  p_align_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    align_exc |-> (!mem_req_valid && !rf_we && !base_we));

  // R9: an alignment exception only follows an accepted operation
  p_align_cause_r9: assert property (@(posedge clk) disable iff (rst)
    align_exc |-> $past(op_valid && op_ready));

  // R10: a stalled request holds its contents
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be) && $stable(mem_req_wdata)));

  // R10: no new operation while a request is outstanding
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !op_ready);

  // R10: register writes only follow a response
  p_write_src_r10: assert property (@(posedge clk) disable iff (rst)
    (rf_we || base_we) |-> $past(mem_rsp_valid));

  // R4: a faulting response suppresses both writes
  p_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && mem_rsp_fault) |=> (!rf_we && !base_we));

  // R8: enables cover one, two or four lanes
  p_be_shape_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> ($countones(mem_req_be) == 1 || $countones(mem_req_be) == 2 ||
                       $countones(mem_req_be) == 4));
endmodule

bind lsu_addr_fmt lsu_addr_fmt_chk u_chk (.*);

// File: tb/lsu_addr_fmt_test.sv
module lsu_addr_fmt_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        op_store = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic        op_signed = 1'b0;
  logic        op_brev = 1'b0;
  logic        op_update = 1'b0;
  logic        op_indexed = 1'b0;
  logic        op_align = 1'b0;
  logic [4:0]  ra_idx = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] rb_val = '0;
  logic [15:0] disp = '0;
  logic [4:0]  rt_idx = '0;
  logic [31:0] st_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_req_we;
  logic [3:0]  mem_req_be;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_fault = 1'b0;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        base_we;
  logic [4:0]  base_waddr;
  logic [31:0] base_wdata;
  logic        align_exc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_addr_fmt uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic do_op(input bit st, input logic [1:0] sz, input bit sg, input bit br,
                       input bit up, input bit ix, input bit al, input logic [4:0] ra,
                       input logic [31:0] rav, input logic [31:0] rbv, input logic [15:0] dsp,
                       input logic [4:0] rt, input logic [31:0] sd, input logic [31:0] rd,
                       input bit flt, input int stall, input bit gap);
    logic [31:0] base, ea, exp_wd, exp_ld;
    logic [3:0]  exp_be;
    logic [15:0] h;
    logic [1:0]  lo;
    bit          mis;
    base = (up || ra != 0) ? rav : 32'h0;
    ea   = base + (ix ? rbv : {{16{dsp[15]}}, dsp});
    lo   = ea[1:0];
    mis  = al && (lo != 2'b00);
    if (sz == 2'd0) begin
      exp_be = 4'b1000 >> lo;
      exp_wd = {24'h0, sd[7:0]} << (8 * (3 - lo));
      exp_ld = (rd >> (8 * (3 - lo))) & 32'hFF;
    end else if (sz == 2'd1) begin
      exp_be = lo[1] ? 4'b0011 : 4'b1100;
      h      = br ? {sd[7:0], sd[15:8]} : sd[15:0];
      exp_wd = lo[1] ? {16'h0, h} : {h, 16'h0};
      h      = lo[1] ? rd[15:0] : rd[31:16];
      if (br) h = {h[7:0], h[15:8]};
      exp_ld = (sg && h[15]) ? {16'hFFFF, h} : {16'h0, h};
    end else begin
      exp_be = 4'b1111;
      exp_wd = br ? sw32(sd) : sd;
      exp_ld = br ? sw32(rd) : rd;
    end

    @(negedge clk);
    op_valid = 1'b1; op_store = st; op_size = sz; op_signed = sg; op_brev = br;
    op_update = up; op_indexed = ix; op_align = al; ra_idx = ra; ra_val = rav;
    rb_val = rbv; disp = dsp; rt_idx = rt; st_data = sd;
    @(negedge clk);
    op_valid = 1'b0;
    if (mis) begin
      chk(align_exc === 1'b1, "R9", "align_exc", {31'h0, align_exc}, 32'h1);
      chk(mem_req_valid === 1'b0, "R9", "no request", {31'h0, mem_req_valid}, 32'h0);
      chk(!rf_we && !base_we, "R9", "no writes", {30'h0, rf_we, base_we}, 32'h0);
      @(negedge clk);
      chk(!rf_we && !base_we && !mem_req_valid, "R9", "quiet after", {30'h0, rf_we, base_we}, 32'h0);
      return;
    end
    chk(align_exc === 1'b0, "R9", "no exception", {31'h0, align_exc}, 32'h0);
    chk(mem_req_valid === 1'b1, "R10", "request valid", {31'h0, mem_req_valid}, 32'h1);
    chk(op_ready === 1'b0, "R10", "busy", {31'h0, op_ready}, 32'h0);
    chk(mem_req_addr === ea, ix ? "R2" : "R1", "address", mem_req_addr, ea);
    chk(mem_req_we === st, "R8", "write flag", {31'h0, mem_req_we}, {31'h0, st});
    chk(mem_req_be === exp_be, "R8", "byte enables", {28'h0, mem_req_be}, {28'h0, exp_be});
    if (st) chk(mem_req_wdata === exp_wd, "R8", "store lanes", mem_req_wdata, exp_wd);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(mem_req_valid === 1'b1 && mem_req_addr === ea, "R10", "held under stall", mem_req_addr, ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid === 1'b0, "R10", "request taken", {31'h0, mem_req_valid}, 32'h0);
    if (gap) begin
      @(negedge clk);
      chk(!rf_we && !base_we && !op_ready, "R10", "waiting", {29'h0, rf_we, base_we, op_ready}, 32'h0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = rd; mem_rsp_fault = flt;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0;
    chk(op_ready === 1'b1, "R10", "ready after response", {31'h0, op_ready}, 32'h1);
    if (flt) begin
      chk(!rf_we && !base_we, "R4", "fault suppresses writes", {30'h0, rf_we, base_we}, 32'h0);
    end else begin
      chk(rf_we === !st, "R10", "rf_we only for loads", {31'h0, rf_we}, {31'h0, !st});
      if (!st) begin
        chk(rf_waddr === rt, "R10", "target index", {27'h0, rf_waddr}, {27'h0, rt});
        chk(rf_wdata === exp_ld, sz == 2'd0 ? "R5" : (sz == 2'd1 ? "R6" : "R7"),
            "load value", rf_wdata, exp_ld);
      end
      chk(base_we === up, "R3", "base write flag", {31'h0, base_we}, {31'h0, up});
      if (up) begin
        chk(base_waddr === ra, "R3", "base index", {27'h0, base_waddr}, {27'h0, ra});
        chk(base_wdata === ea, "R3", "base value", base_wdata, ea);
      end
    end
  endtask

  initial begin
    int n;
    logic [31:0] rdw;
    logic [4:0]  rai;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(op_ready === 1'b1, "R11", "op_ready", {31'h0, op_ready}, 32'h1);
    chk(!mem_req_valid && !rf_we && !base_we && !align_exc, "R11", "outputs idle",
        {28'h0, mem_req_valid, rf_we, base_we, align_exc}, 32'h0);

    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 3; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int br = 0; br < 2; br++)
            for (int up = 0; up < 2; up++)
              for (int ix = 0; ix < 2; ix++)
                for (int z = 0; z < 2; z++)
                  for (int lo = 0; lo < 4; lo++)
                    for (int flt = 0; flt < 2; flt++) begin
                      rdw = (32'h8C7A_E513 << (n % 8)) | (32'h8C7A_E513 >> (32 - (n % 8)));
                      rdw = rdw ^ {4{n[7:0]}};
                      rai = (z != 0) ? 5'd0 : 5'd3 + 5'(n % 4);
                      do_op(st[0], 2'(sz), sg[0], br[0], up[0], ix[0], 1'b0, rai,
                            32'h0001_2340 + 32'(n * 64), 32'h0000_0200 | 32'(lo),
                            16'hFF80 | 16'(lo), 5'd7 + 5'(n % 8),
                            32'hC3A5_9E71 ^ 32'(n * 32'h0001_0203), rdw,
                            flt[0], n % 3, n[0]);
                      n++;
                    end

    for (int st = 0; st < 2; st++)
      for (int up = 0; up < 2; up++)
        for (int ix = 0; ix < 2; ix++)
          for (int lo = 0; lo < 4; lo++) begin
            do_op(st[0], 2'd2, 1'b0, 1'b0, up[0], ix[0], 1'b1, 5'd4,
                  32'h0040_0000, 32'h0000_0010 | 32'(lo), 16'h0020 | 16'(lo),
                  5'd9, 32'h1234_5678, 32'hCAFE_F00D, 1'b0, lo % 2, 1'b0);
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule